// File: doc/BRIEF.md
# Framebuffer Raster Timing Generator

This block walks a raster one video clock at a time and marks where the framebuffer reader is. It outputs a one-cycle line marker, a one-cycle frame marker and a display-enable strobe. The marks are positional. Pulse width and polarity for any particular video standard are left to whatever consumes them. A separate downstream stage uses the markers to generate pixel addresses and to shape real sync pulses.

Three 32-bit configuration words set the raster. They hold the active size, the horizontal porches and the vertical porches. Each length is stored as its count minus one. The words are written and read back on a small register port in its own clock domain. A change is passed into the video domain with a toggle flag synchronised through two flip-flops. The new geometry is applied only at the wrap into a new frame, so a frame in progress always keeps one consistent geometry.

Top module: `fb_raster_timer`

## Requirements
- R1: `hsync` is high for exactly one video clock at the first position of every line, and is low at every other position.
- R2: `vsync` is high for exactly one video clock per frame, in the same cycle as the `hsync` of the frame's first line.
- R3: Each line is laid out as follows. The first (HB+1) pixels are the sync cycle plus back porch. The next (HA+1) pixels are active. The last (HF+1) pixels are the front porch. `de` is never high outside the active pixels.
- R4: Each frame is laid out the same way, counted in lines: (VB+1) lines, then (VA+1) active lines, then (VF+1) lines. `de` is high only where both the pixel and the line are active.
- R5: Register port word addresses are 0 for size, 1 for horizontal porches and 2 for vertical porches. In every word, bits [9:0] hold the low field and bits [25:16] hold the high field. The size word holds HA low and VA high. The horizontal porch word holds HB low and HF high. The vertical porch word holds VB low and VF high.
- R6: Read-back on `cfg_rdata` returns the stored fields with bits [31:26] and [15:10] as zero. A write to address 3 changes no register and no timing, and address 3 reads as zero.
- R7: A written geometry takes effect from the next frame start. The frame already in progress finishes with the previous geometry.
- R8: While `rst_n` is low, and on the first cycle after its release, the raster sits at the sync position of line 0, so `hsync` and `vsync` are high and `de` is low. The reset geometry is HA=7, VA=3, HB=1, HF=1, VB=0 and VF=0, a 12 by 6 raster with 8 by 4 active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Register port clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| cfg_we | input | 1 | Write strobe, sampled on `cfg_clk` |
| cfg_addr | input | AW (2) | Word address for write and read-back |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read-back of the addressed word, combinational |
| vid_clk | input | 1 | Video clock |
| hsync | output | 1 | One-cycle line-start marker |
| vsync | output | 1 | One-cycle frame-start marker |
| de | output | 1 | Display enable, high on active pixels |

## Verification
The line marker and the frame marker share one cycle at every frame start. That same wrap cycle is also where a pending geometry change is applied. The bench writes new geometries both just after a frame marker and in the middle of a frame, including minimal porches where the sync cycle is the whole back porch and the active region starts on the next pixel. A behavioural raster model loads its geometry only at its own frame wrap. It is compared with `hsync`, `vsync` and `de` on every video clock, so a coinciding marker pair that is missing, or a geometry applied early, shows up as a mismatch in that exact cycle.

// File: rtl/fb_raster_timer.sv
module fb_raster_timer #(
  parameter int FW = 10,
  parameter int AW = 2,
  parameter int DEF_HA = 7,
  parameter int DEF_VA = 3,
  parameter int DEF_HB = 1,
  parameter int DEF_HF = 1,
  parameter int DEF_VB = 0,
  parameter int DEF_VF = 0
) (
  input  logic          cfg_clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          vid_clk,
  output logic          hsync,
  output logic          vsync,
  output logic          de
);
  localparam int CW = FW + 2;
  localparam logic [31:0] FMASK = ((32'd1 << FW) - 32'd1) | (((32'd1 << FW) - 32'd1) << 16);

  logic [FW-1:0] s_ha, s_va, s_hb, s_hf, s_vb, s_vf;
  logic [FW-1:0] a_ha, a_va, a_hb, a_hf, a_vb, a_vf;
  logic          tgl, pend, load;
  logic [2:0]    sy;
  logic [CW-1:0] hcnt, vcnt, htot, vtot;
  logic          line_end, frame_end, h_on, v_on;

  function automatic logic [31:0] pack(input logic [FW-1:0] hi, input logic [FW-1:0] lo);
    return (32'(hi) << 16) | 32'(lo);
  endfunction

  wire hit = cfg_we && (cfg_addr < AW'(3));

  always_ff @(posedge cfg_clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ha <= FW'(DEF_HA); s_va <= FW'(DEF_VA);
      s_hb <= FW'(DEF_HB); s_hf <= FW'(DEF_HF);
      s_vb <= FW'(DEF_VB); s_vf <= FW'(DEF_VF);
      tgl  <= 1'b0;
    end else if (hit) begin
      tgl <= ~tgl;
      case (cfg_addr)
        AW'(0):  begin s_ha <= cfg_wdata[FW-1:0]; s_va <= cfg_wdata[16+:FW]; end
        AW'(1):  begin s_hb <= cfg_wdata[FW-1:0]; s_hf <= cfg_wdata[16+:FW]; end
        default: begin s_vb <= cfg_wdata[FW-1:0]; s_vf <= cfg_wdata[16+:FW]; end
      endcase
    end
  end

  assign cfg_rdata = (cfg_addr == AW'(0)) ? pack(s_va, s_ha) :
                     (cfg_addr == AW'(1)) ? pack(s_hf, s_hb) :
                     (cfg_addr == AW'(2)) ? pack(s_vf, s_vb) : 32'd0;

  assign htot      = CW'(a_hb) + CW'(a_ha) + CW'(a_hf) + CW'(3);
  assign vtot      = CW'(a_vb) + CW'(a_va) + CW'(a_vf) + CW'(3);
  assign line_end  = (hcnt == htot - CW'(1));
  assign frame_end = line_end && (vcnt == vtot - CW'(1));
  assign load      = frame_end && pend;

  always_ff @(posedge vid_clk or negedge rst_n) begin
    if (!rst_n) begin
      sy   <= '0;
      pend <= 1'b0;
      hcnt <= '0;
      vcnt <= '0;
      a_ha <= FW'(DEF_HA); a_va <= FW'(DEF_VA);
      a_hb <= FW'(DEF_HB); a_hf <= FW'(DEF_HF);
      a_vb <= FW'(DEF_VB); a_vf <= FW'(DEF_VF);
    end else begin
      sy   <= {sy[1:0], tgl};
      pend <= (pend && !load) || (sy[2] != sy[1]);
      if (line_end) begin
        hcnt <= '0;
        vcnt <= frame_end ? '0 : vcnt + CW'(1);
      end else begin
        hcnt <= hcnt + CW'(1);
      end
      if (load) begin
        a_ha <= s_ha; a_va <= s_va;
        a_hb <= s_hb; a_hf <= s_hf;
        a_vb <= s_vb; a_vf <= s_vf;
      end
    end
  end

  assign h_on  = (hcnt > CW'(a_hb)) && (hcnt <= CW'(a_hb) + CW'(a_ha) + CW'(1));
  assign v_on  = (vcnt > CW'(a_vb)) && (vcnt <= CW'(a_vb) + CW'(a_va) + CW'(1));
  assign hsync = (hcnt == '0);
  assign vsync = hsync && (vcnt == '0);
  assign de    = h_on && v_on;

  p_hsync_one_cycle_r1: assert property (@(posedge vid_clk) disable iff (!rst_n)
    hsync |=> !hsync);
  p_vsync_on_hsync_r2: assert property (@(posedge vid_clk) disable iff (!rst_n)
    vsync |-> hsync);
  p_vsync_then_line1_r2: assert property (@(posedge vid_clk) disable iff (!rst_n)
    (vsync && !frame_end) |=> (hcnt != '0 || vcnt != '0));
  p_no_de_on_sync_r3: assert property (@(posedge vid_clk) disable iff (!rst_n)
    hsync |-> !de);
  p_hcnt_in_line_r3: assert property (@(posedge vid_clk) disable iff (!rst_n)
    hcnt < htot);
  p_vcnt_in_frame_r4: assert property (@(posedge vid_clk) disable iff (!rst_n)
    vcnt < vtot);
  p_rsvd_zero_r6: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (cfg_rdata & ~FMASK) == 32'd0);
  p_addr3_reads_zero_r6: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (cfg_addr == AW'(3)) |-> (cfg_rdata == 32'd0));
  p_geom_at_frame_start_r7: assert property (@(posedge vid_clk) disable iff (!rst_n)
    !$stable({a_ha, a_va, a_hb, a_hf, a_vb, a_vf}) |-> (hcnt == '0 && vcnt == '0));
endmodule

// File: tb/sim_fb_raster_timer.sv
module sim_fb_raster_timer;
  localparam int VID_T = 10;
  localparam int CFG_T = 14;

  logic        cfg_clk = 0, vid_clk = 0, rst_n = 0, cfg_we = 0;
  logic [1:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic        hsync, vsync, de;

  int checks = 0, errors = 0, frames = 0;
  int mh = 0, mv = 0;
  int act[6], cfg[6];   // ha, va, hb, hf, vb, vf

  fb_raster_timer u0 (.cfg_clk(cfg_clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .vid_clk(vid_clk),
    .hsync(hsync), .vsync(vsync), .de(de));

  always #(VID_T/2) vid_clk = ~vid_clk;
  always #(CFG_T/2) cfg_clk = ~cfg_clk;

  task automatic set_defaults(output int g[6]);
    g[0] = 7; g[1] = 3; g[2] = 1; g[3] = 1; g[4] = 0; g[5] = 0;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got=%h exp=%h t=%0t", req, what, got, exp, $time);
    end
  endtask

  // cycle-by-cycle raster model, compared away from the active edge
  always @(negedge vid_clk) begin
    logic eh, ev, ed;
    int htot, vtot;
    if (!rst_n) begin
      mh = 0; mv = 0; set_defaults(act);
    end
    eh = (mh == 0);
    ev = eh && (mv == 0);
    ed = (mh > act[2]) && (mh <= act[2] + act[0] + 1) && (mv > act[4]) && (mv <= act[4] + act[1] + 1);
    if (!rst_n) begin
      chk("R8", "hsync in reset", hsync, 1); chk("R8", "vsync in reset", vsync, 1); chk("R8", "de in reset", de, 0);
    end else begin
      chk("R1", "hsync", hsync, eh);
      chk("R2", "vsync", vsync, ev);
      chk("R3/R4", "de", de, ed);
      htot = act[2] + act[0] + act[3] + 3;
      vtot = act[4] + act[1] + act[5] + 3;
      mh++;
      if (mh == htot) begin
        mh = 0; mv++;
        if (mv == vtot) begin
          mv = 0; act = cfg; frames++;   // R7: geometry only at frame wrap
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge cfg_clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge cfg_clk); cfg_we = 0;
    if (a == 0) begin cfg[0] = int'(d[9:0]); cfg[1] = int'(d[25:16]); end
    if (a == 1) begin cfg[2] = int'(d[9:0]); cfg[3] = int'(d[25:16]); end
    if (a == 2) begin cfg[4] = int'(d[9:0]); cfg[5] = int'(d[25:16]); end
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [31:0] exp);
    @(negedge cfg_clk); cfg_addr = a;
    #1 chk(req, "readback", cfg_rdata, exp);
  endtask

  task automatic wait_frames(input int n);
    int target = frames + n;
    while (frames < target) @(posedge vid_clk);
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(VID_T * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    set_defaults(cfg);
    set_defaults(act);
    repeat (4) @(posedge vid_clk);
    @(posedge vid_clk); #2 rst_n = 1;
    // R5/R6: reset values read back with reserved bits zero
    rd("R5", 0, 32'h0003_0007);
    rd("R5", 1, 32'h0001_0001);
    rd("R5", 2, 32'h0000_0000);
    rd("R6", 3, 32'h0000_0000);
    wait_frames(2);
    // new geometry just after a frame start, reserved bits set in write data
    @(negedge vid_clk);
    wr(0, 32'hFC05_FC09);
    wr(1, 32'hFC00_0000);   // minimal porches
    wr(2, 32'h0001_0002);
    wr(3, 32'h1234_5678);   // R6: ignored address
    rd("R6", 0, 32'h0005_0009);
    rd("R6", 1, 32'h0000_0000);
    rd("R6", 2, 32'h0001_0002);
    rd("R6", 3, 32'h0000_0000);
    wait_frames(3);
    // R7: mid-frame write must not disturb the current frame
    repeat (20) @(posedge vid_clk);
    wr(0, 32'h0002_0004);
    wr(1, 32'h0002_0003);
    wr(2, 32'h0000_0001);
    rd("R5", 1, 32'h0002_0003);
    wait_frames(3);
    // R6: write to address 3 leaves timing unchanged over further frames
    wr(3, 32'hFFFF_FFFF);
    rd("R6", 0, 32'h0002_0004);
    wait_frames(2);
    finish_run();
  end
endmodule